// File: doc/BRIEF.md
# Masked-Write Open-Drain Line Pair Controller

This block gives software direct control of two open-drain pad lines, one carrying a serial clock and one carrying serial data, so that a two-wire bus such as I2C can be bit-banged from a CPU. One 32-bit control word covers both lines. Each line owns an 8-bit lane in that word. A lane holds a drive-enable field, a drive-level field and a pullup-disable field, and each of these has its own write-enable bit. A write changes a field only when that field's write-enable bit is set in the same write. Software can therefore move one line, or one field of one line, without first reading back the other.

A line goes high when software releases it: it clears the drive-enable field and sets its write-enable bit, and the external pullup then raises the wire. A line goes low when software sets drive-enable to 1 and drive-level to 0, with both write-enable bits set. To sample a line, software releases it and reads the lane's pin bit. The pin bit comes from the external wire level through a two-flop synchroniser. The pad gets an output enable, an output level and a pullup-disable signal for each line.

Top module: `od_gpio_pair`

## Requirements
- R1: After a synchronous active-low reset, every line is released (`pad_oe`=0) with stored level 0 and pullup-disable 0, and both synchronised pin bits are 1. `rd_data` then reads 0x0000_1010.
- R2: Lane k occupies `wr_data`/`rd_data` bits [8k+7:8k]. Line 0 is the clock line and line 1 is the data line. Within a lane, bit 1 is drive-enable (1 = drive) and is written only when bit 0 (its write-enable) is 1 in the same write. The new value shows on `rd_data` and on `pad_oe` one clock after the write.
- R3: Lane bit 3 is the drive level and is written only when lane bit 2 is 1 in the same write. `pad_out` shows the stored level one clock after the write.
- R4: Lane bit 6 is pullup-disable and is written only when lane bit 5 is 1. In every other write it holds its value. It drives `pad_pu_off`.
- R5: The write-enable bits of one lane have no effect on the other lane's fields.
- R6: A release write (drive-enable 0 with its write-enable bit set, level write-enable bit 0) deasserts `pad_oe` and leaves the stored level unchanged.
- R7: A drive-low write (drive-enable 1, level 0, both write-enable bits set) gives `pad_oe`=1 and `pad_out`=0 one clock later.
- R8: Lane bit 4 reads the external pin level of that line through a two-flop synchroniser. A pin change shows on `rd_data` after the second rising clock edge, and not after the first. Bit 4 of `wr_data` is ignored.
- R9: The write-enable bits 0, 2 and 5 of each lane, bit 7 of each lane and bits 31:16 always read as 0. Writes to bits 7 and 31:16 have no effect.
- R10: While `wr_en` is 0, no stored field changes, whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word with per-field write-enable bits |
| rd_data | output | 32 | Readback of the control word; write-enable bits read 0 |
| pin_in | input | 2 | External wire levels, bit 0 clock line, bit 1 data line |
| pad_oe | output | 2 | Pad output enable per line (1 = pull the wire low) |
| pad_out | output | 2 | Pad output level per line |
| pad_pu_off | output | 2 | Pullup disable per line |

## Verification
The bench sweeps every combination of the seven writable lane bits on both lanes at once, 16384 writes. After each write it compares the readback and pad outputs against an arithmetic model. A design that ignored a write-enable bit would corrupt the field that bit guards. A design that crossed the lanes would move the other line. A design that copied a write-enable bit into the readback would show nonzero bits where zero is required. Separate checks cover the following:
- Pin sampling one edge after a change and two edges after it, which catches a synchroniser that is one stage short or one stage long.
- A strobe-low write with all enables set, which catches a design that updates without `wr_en`.
- A release write, which catches a design that clears the stored level when the line is released.

// File: rtl/od_gpio_pkg.sv
// Package: shared lane layout and per-line state for the open-drain pair.
// Assumes each line owns one 8-bit lane of the control word.
package od_gpio_pkg;
    localparam int LANE_W  = 8;
    // Bit positions inside one lane (software decodes these)
    localparam int DIR_WE  = 0;
    localparam int DIR_BIT = 1;
    localparam int VAL_WE  = 2;
    localparam int VAL_BIT = 3;
    localparam int PIN_BIT = 4;
    localparam int PU_WE   = 5;
    localparam int PU_BIT  = 6;

    typedef struct packed {
        logic pu_off;
        logic val;
        logic dir;
    } line_state_t;
endpackage

// File: rtl/od_sync.sv
// Module: multi-stage flop synchroniser for asynchronous pin levels.
// Assumes STAGES >= 1; the reset value applies to every stage.
module od_sync #(
    parameter int   W       = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin level one stage further along the chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= {W{RST_VAL}};
                else if (s == 0)
                    stage_q[s] <= async_in;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/od_line_reg.sv
// Module: stored fields of one line, each guarded by its own write enable.
// Assumes the lane byte follows the layout in od_gpio_pkg.
module od_line_reg
    import od_gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] lane_wr,
    output line_state_t       state
);
    line_state_t state_q;

    // Masked update: a field moves only when its own enable bit is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (wr_en) begin
            if (lane_wr[DIR_WE]) state_q.dir    <= lane_wr[DIR_BIT];
            if (lane_wr[VAL_WE]) state_q.val    <= lane_wr[VAL_BIT];
            if (lane_wr[PU_WE])  state_q.pu_off <= lane_wr[PU_BIT];
        end
    end

    assign state = state_q;
endmodule

// File: rtl/od_gpio_pair.sv
// Module: control word and open-drain pad outputs for a clock/data line pair.
// Assumes REG_W >= NUM_LINES*LANE_W; the unused upper bits read as zero.
module od_gpio_pair
    import od_gpio_pkg::*;
#(
    parameter int NUM_LINES   = 2,
    parameter int REG_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_pu_off
);
    localparam int USED_W = NUM_LINES * LANE_W;

    logic [NUM_LINES-1:0] pin_sync;

    od_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_LINES; k++) begin : g_line
            line_state_t st;

            od_line_reg i_line (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_en),
                .lane_wr (wr_data[k*LANE_W +: LANE_W]),
                .state   (st)
            );

            // Open drain: enable only when driving, level is the stored value
            assign pad_oe[k]     = st.dir;
            assign pad_out[k]    = st.val;
            assign pad_pu_off[k] = st.pu_off;

            // Readback lane: stored fields and pin, enable bits forced to 0
            always_comb begin
                rd_data[k*LANE_W +: LANE_W]          = '0;
                rd_data[k*LANE_W + DIR_BIT]          = st.dir;
                rd_data[k*LANE_W + VAL_BIT]          = st.val;
                rd_data[k*LANE_W + PIN_BIT]          = pin_sync[k];
                rd_data[k*LANE_W + PU_BIT]           = st.pu_off;
            end
        end

        if (REG_W > USED_W) begin : g_pad_zero
            assign rd_data[REG_W-1:USED_W] = '0;
        end
    endgenerate
endmodule

// File: rtl/od_gpio_pair_chk.sv
// Module: property checker for od_gpio_pair, attached by bind.
// Assumes the default two-stage synchroniser for the pin latency check.
module od_gpio_pair_chk
    import od_gpio_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int REG_W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [REG_W-1:0]     wr_data,
    input logic [REG_W-1:0]     rd_data,
    input logic [NUM_LINES-1:0] pin_in,
    input logic [NUM_LINES-1:0] pad_oe,
    input logic [NUM_LINES-1:0] pad_out,
    input logic [NUM_LINES-1:0] pad_pu_off
);
    logic [1:0] live_cnt;

    // Count clocks since reset so pin history checks start late enough
    always_ff @(posedge clk) begin
        if (!rst_n)                live_cnt <= '0;
        else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
    end

    genvar k;
    generate
        for (k = 0; k < NUM_LINES; k++) begin : g_chk
            localparam int B = k * LANE_W;

            // R2
            dir_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[B+DIR_WE]) |=> (pad_oe[k] == $past(wr_data[B+DIR_BIT])));
            // R2
            dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_en || !wr_data[B+DIR_WE]) |=> $stable(pad_oe[k]));
            // R3
            val_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_data[B+VAL_WE]) |=> (pad_out[k] == $past(wr_data[B+VAL_BIT])));
            // R6
            val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_en || !wr_data[B+VAL_WE]) |=> $stable(pad_out[k]));
            // R4
            pu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_en || !wr_data[B+PU_WE]) |=> $stable(pad_pu_off[k]));
            // R8
            pin_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (live_cnt >= 2'd2) |-> (rd_data[B+PIN_BIT] == $past(pin_in[k], 2)));
            // R9
            we_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_data[B+DIR_WE] == 1'b0) && (rd_data[B+VAL_WE] == 1'b0) &&
                (rd_data[B+PU_WE] == 1'b0) && (rd_data[B+7] == 1'b0));
        end
    endgenerate
endmodule

bind od_gpio_pair od_gpio_pair_chk #(.NUM_LINES(NUM_LINES), .REG_W(REG_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .pin_in     (pin_in),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pu_off (pad_pu_off)
);

// File: tb/test_od_gpio_pair.sv
// Bench: full sweep of lane write patterns against an arithmetic line model.
module test_od_gpio_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  pin_in = 2'b11;
    logic [1:0]  pad_oe, pad_out, pad_pu_off;

    int n_tests = 0;
    int n_fail  = 0;
    logic [1:0] m_dir = '0, m_val = '0, m_pu = '0, m_pin = 2'b11;

    always #4 clk = ~clk;

    od_gpio_pair i_od_gpio_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu_off(pad_pu_off)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        logic [31:0] r = '0;
        for (int k = 0; k < 2; k++) begin
            r[8*k+1] = m_dir[k];
            r[8*k+3] = m_val[k];
            r[8*k+4] = m_pin[k];
            r[8*k+6] = m_pu[k];
        end
        return r;
    endfunction

    // Apply a write model: each field moves only with its enable bit
    task automatic model_write(input logic [31:0] d);
        for (int k = 0; k < 2; k++) begin
            if (d[8*k+0]) m_dir[k] = d[8*k+1];
            if (d[8*k+2]) m_val[k] = d[8*k+3];
            if (d[8*k+5]) m_pu[k]  = d[8*k+6];
        end
    endtask

    task automatic do_write(input logic [31:0] d, input logic en);
        @(negedge clk);
        wr_en   = en;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        if (en) model_write(d);
    endtask

    task automatic check_all(input string tag);
        check(rd_data == exp_rd(), tag, rd_data, exp_rd());
        check({pad_oe, pad_out, pad_pu_off} == {m_dir, m_val, m_pu}, tag,
              {26'd0, pad_oe, pad_out, pad_pu_off}, {26'd0, m_dir, m_val, m_pu});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 32'h0000_1010, "R1 reset readback", rd_data, 32'h0000_1010);
        check({pad_oe, pad_out, pad_pu_off} == 6'd0, "R1 reset pads",
              {26'd0, pad_oe, pad_out, pad_pu_off}, 32'd0);

        // R7 drive clock line low, R6 release it keeping the level
        do_write(32'h0000_0007, 1'b1);
        check(pad_oe[0] && !pad_out[0], "R7 drive low", {30'd0, pad_oe[0], pad_out[0]}, 32'd2);
        do_write(32'h0000_000F, 1'b1);
        do_write(32'h0000_0001, 1'b1);
        check(!pad_oe[0] && pad_out[0], "R6 release keeps level",
              {30'd0, pad_oe[0], pad_out[0]}, 32'd1);
        check_all("R6 release readback");

        // R10 strobe low with every enable set
        do_write(32'hFFFF_FFFF, 1'b0);
        check_all("R10 no write without strobe");

        // R8 synchroniser latency on both lines
        @(negedge clk);
        pin_in = 2'b00;
        @(negedge clk);
        check(rd_data[4] == 1'b1 && rd_data[12] == 1'b1, "R8 one edge old",
              {30'd0, rd_data[12], rd_data[4]}, 32'd3);
        @(negedge clk);
        m_pin = 2'b00;
        check(rd_data[4] == 1'b0 && rd_data[12] == 1'b0, "R8 two edges new",
              {30'd0, rd_data[12], rd_data[4]}, 32'd0);

        // R2 R3 R4 R5 R9 sweep every lane pattern on both lanes together
        for (int o = 0; o < 128; o++) begin
            @(negedge clk);
            pin_in = o[1:0];
            repeat (2) @(negedge clk);
            m_pin = o[1:0];
            for (int i = 0; i < 128; i++) begin
                logic [31:0] d;
                d = {o[7:0] ^ i[7:0], i[7:0], 1'b0, o[6:0], i[0] ^ o[0], i[6:0]};
                d[15] = o[1];
                do_write(d, 1'b1);
                check_all("R2/R3/R4/R5/R9 sweep");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule